// File: doc/BRIEF.md
# Multi-channel interprocessor mailbox controller

This block lets a local processor hand fixed-length messages to a remote processor through a set of independent channels. Each channel has its own 64-byte register window on a simple read/write register bus. A requester claims a channel by writing a single ownership bit and reading it back. It then picks which interrupt lines toward the remote side are raised, fills eight data words and triggers delivery. The remote side answers with an acknowledge pulse. When automatic acknowledge is selected, that pulse drops the interrupt and parks the channel in an acknowledged state. The owner then clears that state to send again.

Each channel goes through idle, acquired, ready, sent and acknowledged. A global lock register guards every channel register write. Only a fixed key opens it, and any other value written there closes it again. Reads have no side effects and return zero for every offset that is not mapped.

Top module: `mbx_ctrl`

## Requirements
- R1: After reset every channel is idle, so its mode register reads 0x10. The lock register at byte address 0xA00 reads 1. Every interrupt mask register reads all ones (0xFF with 8 vector bits). The interrupt output is all zero.
- R2: Writing 0x1ACCE551 to 0xA00 unlocks the block, and the lock register then reads 0. Writing any other value there locks it again and it reads 1. While locked, writes to channel registers change nothing.
- R3: Channel c sits at byte base c*0x40 and its source register is at offset 0x00. In the idle state, a source write with exactly one bit set inside the vector width claims the channel. That value then reads back, and mode bit 5 (ready) is set, so mode reads 0x20 plus the auto bit. A source write with zero or several bits set has no effect in idle, and neither does a nonzero source write to an owned channel.
- R4: Writing 0 to the source register of an owned channel releases it. Mode reads 0x10 again, and the destination set, the pending interrupts and that channel's interrupt outputs all become zero.
- R5: Offset 0x04 ORs written bits into the destination set. The send register is at offset 0x1C. Writing exactly the owner's source value there while the channel is acquired or ready makes the current destination set pending. Mode then shows bit 6 (busy) and reads 0x40 plus the auto bit. A send with any other value is ignored.
- R6: Channel c drives bits [c*VEC_W +: VEC_W] of the interrupt output, and they equal pending AND NOT mask. The mask register is at offset 0x14, and a 0 bit enables the line. A mask write changes the outputs from the next cycle.
- R7: Writing bits to destination clear (offset 0x08) removes them from the destination set and from the pending interrupts.
- R8: Mode bit 0 (offset 0x10) selects automatic acknowledge. With it set, an acknowledge pulse on ack_i[c] while the channel is sent clears all pending interrupts. It also moves the channel to the acknowledged state, where mode reads 0x81.
- R9: With automatic acknowledge off, an acknowledge pulse leaves the channel sent and its interrupt outputs unchanged.
- R10: In the acknowledged state, writing exactly the owner's value to interrupt clear (offset 0x18) returns the channel to ready, so mode reads 0x21. Any other value is ignored.
- R11: Offsets 0x20 to 0x3C hold eight 32-bit data words, and each reads back the last value written to it.
- R12: Destination status (offset 0x0C) reads pending AND NOT mask. Offsets 0x08, 0x18 and 0x1C read 0. So do unaligned addresses, channel windows at or above NUM_CH, and every other address outside the windows and 0xA00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_o | output | NUM_CH*VEC_W | Interrupt lines toward the remote side, VEC_W per channel |
| ack_i | input | NUM_CH | Remote acknowledge pulse, one per channel |

## Verification
The assertions assume that an acknowledge pulse and a release write to the same channel do not arrive in the same cycle. They also assume that writes carry no bits above the vector width, except where such bits are meant to be rejected. The stimulus raises acknowledge only on channels that are in a known state, and never together with a bus write to that channel. Random values are masked to the vector width wherever they are not testing the one-hot rule.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;
    localparam int unsigned LOCK_ADDR  = 32'hA00;
    localparam int unsigned WIN_SHIFT  = 6;

    localparam logic [3:0] OFS_SRC   = 4'd0;
    localparam logic [3:0] OFS_DST   = 4'd1;
    localparam logic [3:0] OFS_DCLR  = 4'd2;
    localparam logic [3:0] OFS_DSTAT = 4'd3;
    localparam logic [3:0] OFS_MODE  = 4'd4;
    localparam logic [3:0] OFS_MASK  = 4'd5;
    localparam logic [3:0] OFS_ICLR  = 4'd6;
    localparam logic [3:0] OFS_SEND  = 4'd7;

    typedef enum logic [2:0] {
        CH_IDLE,
        CH_ACQ,
        CH_READY,
        CH_SENT,
        CH_ACK
    } ch_state_e;

    typedef struct packed {
        logic                  wr;
        logic [3:0]            widx;
        logic [WORD_W-1:0]     wdata;
    } ch_req_t;

    function automatic logic [WORD_W-1:0] mode_word(ch_state_e s, logic auto_ack);
        logic [WORD_W-1:0] w;
        w    = '0;
        w[0] = auto_ack;
        case (s)
            CH_IDLE:           w[4] = 1'b1;
            CH_ACQ, CH_READY:  w[5] = 1'b1;
            CH_SENT:           w[6] = 1'b1;
            CH_ACK:            w[7] = 1'b1;
            default:           w[4] = 1'b1;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] ch_hit,
    output logic              lock_hit,
    output logic [3:0]        widx
);
    localparam int unsigned IDX_W = ADDR_W - WIN_SHIFT;

    logic             aligned;
    logic [IDX_W-1:0] win_idx;

    assign aligned  = (addr[1:0] == 2'b00);
    assign win_idx  = addr[ADDR_W-1:WIN_SHIFT];
    assign widx     = addr[5:2];
    assign lock_hit = (addr == ADDR_W'(LOCK_ADDR));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
        assign ch_hit[i] = aligned && (win_idx == IDX_W'(i));
    end

endmodule

// File: rtl/mbx_lock.sv
module mbx_lock
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output logic              locked
);
    always_ff @(posedge clk) begin
        if (rst)      locked <= 1'b1;
        else if (wr)  locked <= (wdata != UNLOCK_KEY);
    end

    assert_unlock_key_R2: assert property (@(posedge clk) disable iff (rst)
        (wr && wdata == UNLOCK_KEY) |=> !locked);

    assert_relock_R2: assert property (@(posedge clk) disable iff (rst)
        (wr && wdata != UNLOCK_KEY) |=> locked);

endmodule

// File: rtl/mbx_channel.sv
module mbx_channel
    import mbx_pkg::*;
#(
    parameter int unsigned VEC_W  = 8,
    parameter int unsigned NWORDS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  ch_req_t           req,
    input  logic [3:0]        rd_idx,
    input  logic              ack_i,
    output logic [WORD_W-1:0] rdata,
    output logic [VEC_W-1:0]  irq_o
);
    localparam int unsigned WI_W = $clog2(NWORDS);

    ch_state_e         state;
    logic [VEC_W-1:0]  src, dst, pend, mask;
    logic              auto_ack;
    logic [WORD_W-1:0] data_q [NWORDS];

    logic [WORD_W-1:0] src_w, dst_w, pend_w, mask_w, vec_w, irq_w;
    logic [VEC_W-1:0]  wbits;
    logic              in_range, one_hot, owner_match, is_release, ack_take;

    always_comb begin
        src_w  = '0;  src_w[VEC_W-1:0]  = src;
        dst_w  = '0;  dst_w[VEC_W-1:0]  = dst;
        pend_w = '0;  pend_w[VEC_W-1:0] = pend;
        mask_w = '0;  mask_w[VEC_W-1:0] = mask;
        vec_w  = '0;  vec_w[VEC_W-1:0]  = '1;
        irq_w  = pend_w & ~mask_w;
    end

    assign wbits       = req.wdata[VEC_W-1:0];
    assign in_range    = ((req.wdata & ~vec_w) == '0);
    assign one_hot     = in_range && ($countones(req.wdata) == 1);
    assign owner_match = (req.wdata == src_w);
    assign is_release  = req.wr && (req.widx == OFS_SRC) && (req.wdata == '0)
                         && (state != CH_IDLE);
    assign ack_take    = (state == CH_SENT) && auto_ack && ack_i && !is_release;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= CH_IDLE;
            src      <= '0;
            dst      <= '0;
            pend     <= '0;
            mask     <= '1;
            auto_ack <= 1'b0;
            for (int i = 0; i < NWORDS; i++) data_q[i] <= '0;
        end else begin
            if (req.wr) begin
                if (req.widx[3]) begin
                    data_q[req.widx[WI_W-1:0]] <= req.wdata;
                end else begin
                    case (req.widx)
                        OFS_SRC: begin
                            if (state == CH_IDLE && one_hot) begin
                                src   <= wbits;
                                state <= CH_ACQ;
                            end else if (is_release) begin
                                src   <= '0;
                                dst   <= '0;
                                pend  <= '0;
                                state <= CH_IDLE;
                            end
                        end
                        OFS_DST:  dst <= dst | wbits;
                        OFS_DCLR: begin
                            dst  <= dst & ~wbits;
                            pend <= pend & ~wbits;
                        end
                        OFS_MODE: auto_ack <= req.wdata[0];
                        OFS_MASK: mask <= wbits;
                        OFS_ICLR: begin
                            if (state == CH_ACK && owner_match) state <= CH_READY;
                        end
                        OFS_SEND: begin
                            if ((state == CH_ACQ || state == CH_READY) && owner_match) begin
                                state <= CH_SENT;
                                pend  <= dst;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            if (ack_take) begin
                state <= CH_ACK;
                pend  <= '0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_idx[3]) begin
            rdata = data_q[rd_idx[WI_W-1:0]];
        end else begin
            case (rd_idx)
                OFS_SRC:   rdata = src_w;
                OFS_DST:   rdata = dst_w;
                OFS_DSTAT: rdata = irq_w;
                OFS_MODE:  rdata = mode_word(state, auto_ack);
                OFS_MASK:  rdata = mask_w;
                default:   rdata = '0;
            endcase
        end
    end

    assign irq_o = irq_w[VEC_W-1:0];

    // R4: an idle channel has no owner and nothing pending
    assert_idle_empty_R4: assert property (@(posedge clk) disable iff (rst)
        (state == CH_IDLE) |-> (src == '0 && pend == '0));

    assert_owner_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        (state != CH_IDLE) |-> ($countones(src) == 1));

    assert_send_latch_R5: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.widx == OFS_SEND && owner_match &&
         (state == CH_ACQ || state == CH_READY) && !ack_i)
        |=> (state == CH_SENT && pend == $past(dst)));

    assert_auto_ack_R8: assert property (@(posedge clk) disable iff (rst)
        (state == CH_SENT && auto_ack && ack_i && !req.wr)
        |=> (state == CH_ACK && irq_o == '0));

    assert_manual_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (state == CH_SENT && !auto_ack && !req.wr) |=> (state == CH_SENT));

    assert_ack_exit_R10: assert property (@(posedge clk) disable iff (rst)
        (state == CH_ACK) |=> (state == CH_ACK || state == CH_READY || state == CH_IDLE));

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
    import mbx_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned VEC_W  = 8,
    parameter int unsigned ADDR_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_en,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic [NUM_CH*VEC_W-1:0] irq_o,
    input  logic [NUM_CH-1:0]       ack_i
);
    localparam int unsigned NWORDS = 8;

    logic [NUM_CH-1:0] ch_hit;
    logic              lock_hit;
    logic [3:0]        widx;
    logic              locked;
    logic              wr_go;
    logic [WORD_W-1:0] ch_rd [NUM_CH];

    assign wr_go = bus_en && bus_we;

    mbx_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .addr     (bus_addr),
        .ch_hit   (ch_hit),
        .lock_hit (lock_hit),
        .widx     (widx)
    );

    mbx_lock u_lock (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr_go && lock_hit),
        .wdata  (bus_wdata),
        .locked (locked)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ch_req_t req;
        assign req.wr    = wr_go && ch_hit[c] && !locked;
        assign req.widx  = widx;
        assign req.wdata = bus_wdata;

        mbx_channel #(.VEC_W(VEC_W), .NWORDS(NWORDS)) u_ch (
            .clk    (clk),
            .rst    (rst),
            .req    (req),
            .rd_idx (widx),
            .ack_i  (ack_i[c]),
            .rdata  (ch_rd[c]),
            .irq_o  (irq_o[c*VEC_W +: VEC_W])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (lock_hit) bus_rdata = {31'b0, locked};
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_hit[c]) bus_rdata = bus_rdata | ch_rd[c];
        end
    end

endmodule

// File: tb/sim_mbx_ctrl.sv
module sim_mbx_ctrl;
    localparam int CLK_NS = 10;
    localparam int NCH = 4;
    localparam int VW  = 8;

    logic              clk = 0;
    logic              rst = 1;
    logic              bus_en = 0, bus_we = 0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCH*VW-1:0] irq_o;
    logic [NCH-1:0]    ack_i = '0;

    int total = 0, bad = 0;
    logic [31:0] exp_data [NCH][8];

    always #(CLK_NS/2) clk = ~clk;

    mbx_ctrl #(.NUM_CH(NCH), .VEC_W(VW), .ADDR_W(12)) u0 (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .ack_i(ack_i)
    );

    function automatic logic [11:0] ra(int ch, int ofs);
        return 12'(ch * 64 + ofs);
    endfunction

    function automatic logic [31:0] exp_mode(int st, bit auto_ack);
        // st: 0 idle, 1 ready, 2 sent, 3 ack
        logic [31:0] w;
        w = 32'h10 << st;
        return w | {31'b0, auto_ack};
    endfunction

    function automatic logic [7:0] exp_irq(logic [7:0] pend, logic [7:0] mask);
        return pend & ~mask;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 0;
    endtask

    task automatic rchk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic irqchk(input string req, input int ch, input logic [7:0] exp);
        @(negedge clk);
        #1 chk(req, {24'b0, irq_o[ch*VW +: VW]}, {24'b0, exp});
    endtask

    task automatic pulse_ack(input int ch);
        @(negedge clk); ack_i[ch] = 1'b1;
        @(negedge clk); ack_i[ch] = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 150000);
        bad++; total++;
        $display("FAIL watchdog act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        for (int c = 0; c < NCH; c++)
            for (int w = 0; w < 8; w++) exp_data[c][w] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset state
        rchk("R1 mode", ra(0, 16), exp_mode(0, 0));
        rchk("R1 lock", 12'hA00, 32'd1);
        rchk("R1 mask", ra(3, 20), 32'hFF);
        irqchk("R1 irq", 0, 8'h00);

        // R2 locked writes ignored
        wr(ra(0, 0), 32'h1);
        rchk("R2 locked src", ra(0, 0), 32'h0);
        rchk("R2 locked mode", ra(0, 16), exp_mode(0, 0));
        wr(12'hA00, 32'h1ACCE551);
        rchk("R2 unlock", 12'hA00, 32'd0);
        wr(12'hA00, 32'h1ACCE550);
        rchk("R2 relock", 12'hA00, 32'd1);
        wr(12'hA00, 32'h1ACCE551);

        // R3 claim
        wr(ra(0, 0), 32'h04);
        rchk("R3 claim src", ra(0, 0), 32'h04);
        rchk("R3 claim mode", ra(0, 16), exp_mode(1, 0));
        wr(ra(0, 0), 32'h02);
        rchk("R3 second claim", ra(0, 0), 32'h04);
        wr(ra(1, 0), 32'h03);
        rchk("R3 multi-bit", ra(1, 0), 32'h0);
        wr(ra(1, 0), 32'h100);
        rchk("R3 out of width", ra(1, 16), exp_mode(0, 0));

        // R5/R6/R7/R8/R10 on channel 0
        wr(ra(0, 20), 32'hFD);
        wr(ra(0, 4), 32'h02);
        wr(ra(0, 4), 32'h08);
        rchk("R5 dst or", ra(0, 4), 32'h0A);
        wr(ra(0, 16), 32'h1);
        rchk("R8 auto bit", ra(0, 16), exp_mode(1, 1));
        wr(ra(0, 28), 32'h02);
        rchk("R5 bad send", ra(0, 16), exp_mode(1, 1));
        irqchk("R5 bad send irq", 0, 8'h00);
        wr(ra(0, 28), 32'h04);
        rchk("R5 sent mode", ra(0, 16), exp_mode(2, 1));
        irqchk("R5 irq", 0, exp_irq(8'h0A, 8'hFD));
        rchk("R12 dstat", ra(0, 12), {24'b0, exp_irq(8'h0A, 8'hFD)});
        wr(ra(0, 20), 32'hF5);
        irqchk("R6 mask", 0, exp_irq(8'h0A, 8'hF5));
        wr(ra(0, 8), 32'h08);
        irqchk("R7 dclr irq", 0, 8'h02);
        rchk("R7 dclr dst", ra(0, 4), 32'h02);
        pulse_ack(0);
        rchk("R8 ack mode", ra(0, 16), exp_mode(3, 1));
        irqchk("R8 ack irq", 0, 8'h00);
        wr(ra(0, 24), 32'h01);
        rchk("R10 wrong iclr", ra(0, 16), exp_mode(3, 1));
        wr(ra(0, 24), 32'h04);
        rchk("R10 iclr", ra(0, 16), exp_mode(1, 1));

        // R9 manual mode on channel 2, then R4 release
        wr(ra(2, 0), 32'h01);
        wr(ra(2, 20), 32'h00);
        wr(ra(2, 4), 32'h10);
        wr(ra(2, 16), 32'h0);
        wr(ra(2, 28), 32'h01);
        irqchk("R5 ch2 irq", 2, 8'h10);
        pulse_ack(2);
        rchk("R9 stays sent", ra(2, 16), exp_mode(2, 0));
        irqchk("R9 irq held", 2, 8'h10);
        wr(ra(2, 0), 32'h0);
        rchk("R4 release mode", ra(2, 16), exp_mode(0, 0));
        rchk("R4 release dst", ra(2, 4), 32'h0);
        irqchk("R4 release irq", 2, 8'h00);

        // R12 unmapped reads
        rchk("R12 dclr reads 0", ra(0, 8), 32'h0);
        rchk("R12 send reads 0", ra(0, 28), 32'h0);
        rchk("R12 unaligned", ra(0, 21), 32'h0);
        rchk("R12 ch beyond", ra(5, 16), 32'h0);
        rchk("R12 hole", 12'h900, 32'h0);

        // R11 random data words
        for (int i = 0; i < 200; i++) begin
            int c, w;
            logic [31:0] v;
            c = $urandom_range(NCH - 1);
            w = $urandom_range(7);
            v = $urandom;
            wr(ra(c, 32 + 4 * w), v);
            exp_data[c][w] = v;
            c = $urandom_range(NCH - 1);
            w = $urandom_range(7);
            rchk("R11 data", ra(c, 32 + 4 * w), exp_data[c][w]);
        end

        // R6 random masks on a sent channel 3
        wr(ra(3, 0), 32'h80);
        wr(ra(3, 4), 32'hFF);
        wr(ra(3, 28), 32'h80);
        for (int i = 0; i < 60; i++) begin
            logic [7:0] m;
            m = 8'($urandom);
            wr(ra(3, 20), {24'b0, m});
            irqchk("R6 random mask", 3, exp_irq(8'hFF, m));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule